// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM built from four byte-wide lanes. The lanes share one address bus and one active-low output enable. Each lane has its own active-low chip select and active-low write enable. The host hands over one request at a time: address, write data, byte mask, a read/write flag and a width code. The controller turns the request into a memory read or write cycle. It then answers with a one-clock acknowledge and, for reads, the returned data.

All memory timing minimums are parameters counted in system clock cycles. Each request walks through setup, strobe, hold and bus-turnaround phases. The width code lets the same memory serve the host as 32-bit, 16-bit or 8-bit words by steering the lanes. A build parameter picks how a write ends: either on the rising edge of write enable, with chip select still low, or on the rising edge of chip select, with write enable still low. The data bus is split into an output, an output enable and an input, so the pad tristate stays outside the block.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it falls, every chip select and write enable is high (all four bits set), output enable is high, the data-bus drive enable is 0 and acknowledge is 0.
- R2: With width code 0 (32-bit), the memory address equals host address bits [AW-1:0]. A word written with byte mask 4'b1111 reads back unchanged, with host byte k carried on lane k (data bits 8k+7..8k).
- R3: In 32-bit mode, byte mask bit k gates lane k on writes. A lane whose mask bit is 0 never has chip select and write enable low together, and its stored byte is kept.
- R4: Width code 1 (16-bit): host address bit 0 selects lanes {0,1} (value 0) or lanes {2,3} (value 1), and the memory address is host address bits [AW:1]. Write data bits [15:0] go to the selected pair, with byte mask bits [1:0] gating its low and high lane. Read data returns in bits [15:0] with bits [31:16] zero.
- R5: Width code 2 (8-bit): host address bits [1:0] select the lane, and the memory address is host address bits [AW+1:2]. Only that lane's chip select and write enable are ever asserted, and a write goes ahead only if byte mask bit 0 is 1. Read data returns in bits [7:0] with the rest zero.
- R6: Width code 3 behaves exactly like width code 0.
- R7: A write strobe lasts at least WR_CYC cycles. Output enable stays low for at least RD_CYC cycles on a read. The memory address does not change while any write strobe is active.
- R8: The controller drives the data bus only during a write, and never while output enable is low. It also never drives the bus in the cycle after output enable was low.
- R9: Acknowledge is high for exactly one clock per request. For a read, the read data output holds the returned word in that cycle.
- R10: With WR_END_CS = 0, each write ends when write enable rises while chip select is low. With WR_END_CS = 1, each write ends when chip select rises while write enable is still low.
- R11: Output enable is low only while every write enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_width | input | 2 | Host word width: 0 = 32, 1 = 16, 2 = 8, 3 = 32 |
| req_addr | input | AW+2 | Host address in units of the selected width |
| req_be | input | 4 | Byte mask for writes |
| req_wdata | input | 32 | Write data, right-aligned for narrow widths |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read data, zero-extended for narrow widths |
| mem_addr | output | AW | Memory address |
| mem_dq_o | output | 32 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 32 | Data returned from the memory |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_cs_n | output | 4 | Per-lane active-low chip selects |
| mem_we_n | output | 4 | Per-lane active-low write enables |

## Verification
The bench runs two controllers side by side, one for each write-termination style, against a cycle-level memory model. The model flags short strobes, reads cut short, output enable low during a write, and any cycle where both sides could be driving the bus. A partial write is followed by a full-word read. If the mask were ignored, the kept lanes would come back overwritten. Narrow-width writes are read back as full words, so a lane-steering or address-shift error shows up as a byte in the wrong position. The model counts how each write ends, so if the termination parameter were ignored, the counts of the two instances would match instead of being opposite.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned DW     = LANES * LANE_W;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_TURN
  } phase_e;

  typedef enum logic [1:0] {
    WID_32  = 2'd0,
    WID_16  = 2'd1,
    WID_8   = 2'd2,
    WID_RSV = 2'd3
  } width_e;

  // Pick the host-visible part of a raw memory word.
  function automatic logic [DW-1:0] merge_rd(input logic [1:0] width,
                                             input logic [1:0] sel,
                                             input logic [DW-1:0] bus);
    logic [DW-1:0] res;
    case (width)
      WID_16:  res = {16'h0000, (sel[1] ? bus[31:16] : bus[15:0])};
      WID_8:   res = {24'h000000, bus[{sel, 3'b000} +: 8]};
      default: res = bus;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map
  import sram_ctrl_pkg::*;
#(
  parameter int AW  = 19,
  parameter int HAW = AW + 2
) (
  input  logic [1:0]       width,
  input  logic             is_write,
  input  logic [HAW-1:0]   haddr,
  input  logic [LANES-1:0] be,
  input  logic [DW-1:0]    hwdata,
  output logic [AW-1:0]    maddr,
  output logic [LANES-1:0] lanes,
  output logic [1:0]       sel,
  output logic [DW-1:0]    mwdata
);

  logic [LANES-1:0] pick;
  logic [LANES-1:0] wmask;

  always_comb begin
    case (width)
      WID_16: begin
        maddr = haddr[AW:1];
        sel   = {haddr[0], 1'b0};
        pick  = haddr[0] ? 4'b1100 : 4'b0011;
        wmask = haddr[0] ? {be[1:0], 2'b00} : {2'b00, be[1:0]};
      end
      WID_8: begin
        maddr = haddr[AW+1:2];
        sel   = haddr[1:0];
        pick  = 4'b0001 << haddr[1:0];
        wmask = {LANES{be[0]}};
      end
      default: begin
        maddr = haddr[AW-1:0];
        sel   = 2'b00;
        pick  = {LANES{1'b1}};
        wmask = be;
      end
    endcase
    lanes = is_write ? (pick & wmask) : pick;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mwdata[l*LANE_W +: LANE_W] =
      (width == WID_16) ? hwdata[(l % 2)*LANE_W +: LANE_W] :
      (width == WID_8)  ? hwdata[LANE_W-1:0] :
                          hwdata[l*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int RD_CYC    = 2,
  parameter int WR_CYC    = 2,
  parameter int HOLD_CYC  = 1,
  parameter int TURN_CYC  = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   is_write,
  output phase_e phase_q,
  output phase_e phase_d
);

  localparam int M1   = (SETUP_CYC > RD_CYC) ? SETUP_CYC : RD_CYC;
  localparam int M2   = (WR_CYC > HOLD_CYC) ? WR_CYC : HOLD_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > TURN_CYC) ? M3 : TURN_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  localparam logic [CW-1:0] L_SETUP = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] L_RD    = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] L_WR    = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] L_HOLD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] L_TURN  = CW'(TURN_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = last ? cnt_q : cnt_q - 1'b1;
    case (phase_q)
      PH_IDLE:   if (start) begin phase_d = PH_SETUP; cnt_d = L_SETUP; end
      PH_SETUP:  if (last) begin phase_d = PH_STROBE; cnt_d = is_write ? L_WR : L_RD; end
      PH_STROBE: if (last) begin phase_d = PH_HOLD; cnt_d = L_HOLD; end
      PH_HOLD:   if (last) begin phase_d = PH_TURN; cnt_d = L_TURN; end
      PH_TURN:   if (last) begin phase_d = PH_IDLE; cnt_d = '0; end
      default:   begin phase_d = PH_IDLE; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 19,
  parameter int SETUP_CYC = 1,
  parameter int RD_CYC    = 2,
  parameter int WR_CYC    = 2,
  parameter int HOLD_CYC  = 1,
  parameter int TURN_CYC  = 1,
  parameter bit WR_END_CS = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_width,
  input  logic [AW+1:0] req_addr,
  input  logic [3:0]    req_be,
  input  logic [31:0]   req_wdata,
  output logic          req_ack,
  output logic [31:0]   req_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [31:0]   mem_dq_i,
  output logic          mem_oe_n,
  output logic [3:0]    mem_cs_n,
  output logic [3:0]    mem_we_n
);

  phase_e           phase_q, phase_d;
  logic             accept;
  logic             wr_q, wr_c;
  logic [1:0]       width_q, sel_q;
  logic [LANES-1:0] lanes_q, lanes_c;
  logic [AW-1:0]    map_addr;
  logic [LANES-1:0] map_lanes;
  logic [1:0]       map_sel;
  logic [DW-1:0]    map_wdata;
  logic             in_cycle, in_strobe, wr_cs_on, wr_we_on;
  logic             cs_on, we_on;
  logic [LANES-1:0] cs_n_d, we_n_d;
  logic             oe_n_d, dq_oe_d;

  assign accept = req_valid && !req_ack && (phase_q == PH_IDLE);

  sram_lane_map #(.AW(AW)) u_map (
    .width    (req_width),
    .is_write (req_write),
    .haddr    (req_addr),
    .be       (req_be),
    .hwdata   (req_wdata),
    .maddr    (map_addr),
    .lanes    (map_lanes),
    .sel      (map_sel),
    .mwdata   (map_wdata)
  );

  sram_phase_seq #(
    .SETUP_CYC (SETUP_CYC),
    .RD_CYC    (RD_CYC),
    .WR_CYC    (WR_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .TURN_CYC  (TURN_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .is_write (wr_q),
    .phase_q  (phase_q),
    .phase_d  (phase_d)
  );

  assign wr_c    = accept ? req_write : wr_q;
  assign lanes_c = accept ? map_lanes : lanes_q;

  assign in_cycle  = (phase_d == PH_SETUP) || (phase_d == PH_STROBE) || (phase_d == PH_HOLD);
  assign in_strobe = (phase_d == PH_STROBE);

  // Termination style: which strobe brackets the other during a write.
  if (WR_END_CS) begin : g_end_cs
    assign wr_cs_on = in_strobe;
    assign wr_we_on = in_cycle;
  end else begin : g_end_we
    assign wr_cs_on = in_cycle;
    assign wr_we_on = in_strobe;
  end

  always_comb begin
    cs_on   = wr_c ? wr_cs_on : ((phase_d == PH_SETUP) || in_strobe);
    we_on   = wr_c && wr_we_on;
    cs_n_d  = cs_on ? ~lanes_c : {LANES{1'b1}};
    we_n_d  = we_on ? ~lanes_c : {LANES{1'b1}};
    oe_n_d  = !(!wr_c && in_strobe);
    dq_oe_d = wr_c && in_cycle;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q      <= 1'b0;
      width_q   <= '0;
      sel_q     <= '0;
      lanes_q   <= '0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_cs_n  <= {LANES{1'b1}};
      mem_we_n  <= {LANES{1'b1}};
      req_ack   <= 1'b0;
      req_rdata <= '0;
    end else begin
      mem_cs_n  <= cs_n_d;
      mem_we_n  <= we_n_d;
      mem_oe_n  <= oe_n_d;
      mem_dq_oe <= dq_oe_d;
      req_ack   <= (phase_q == PH_TURN) && (phase_d == PH_IDLE);
      if (accept) begin
        wr_q     <= req_write;
        width_q  <= req_width;
        sel_q    <= map_sel;
        lanes_q  <= map_lanes;
        mem_addr <= map_addr;
        mem_dq_o <= map_wdata;
      end
      if (!wr_q && (phase_q == PH_STROBE) && (phase_d == PH_HOLD))
        req_rdata <= merge_rd(width_q, sel_q, mem_dq_i);
    end
  end

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_oe_n,
  input logic [3:0]    mem_cs_n,
  input logic [3:0]    mem_we_n,
  input logic          mem_dq_oe,
  input logic          req_ack
);

  logic wr_act;
  assign wr_act = |(~mem_cs_n & ~mem_we_n);

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wr_act && $past(wr_act)) |-> $stable(mem_addr)); // R7

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n); // R8

  AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
    $past(!mem_oe_n) |-> !mem_dq_oe); // R8

  AST_ACK_ONE: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack); // R9

  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (&mem_we_n)); // R11

endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_oe_n  (mem_oe_n),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .req_ack   (req_ack)
);

// File: tb/sram_model.sv
module sram_model #(
  parameter int AW     = 19,
  parameter int RD_MIN = 2,
  parameter int WR_MIN = 2
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   dq_w,
  input  logic          dq_w_en,
  input  logic          oe_n,
  input  logic [3:0]    cs_n,
  input  logic [3:0]    we_n,
  output logic [31:0]   dq_r,
  output int            viol,
  output int            term_we,
  output int            term_cs,
  output int            max_cs,
  output logic [3:0]    strobed
);

  logic [7:0]    store [logic [AW+1:0]];
  logic [3:0]    act_p = '0;
  logic          drv_p = 1'b0;
  logic [AW-1:0] addr_p = '0;
  logic [31:0]   data_p = '0;
  int            wcnt [4] = '{0, 0, 0, 0};
  int            rcnt = 0;

  initial begin
    dq_r = '0; viol = 0; term_we = 0; term_cs = 0; max_cs = 0; strobed = '0;
  end

  always @(negedge clk) begin
    logic [3:0] act, drv;
    act = ~cs_n & ~we_n;
    drv = ~cs_n & we_n & {4{~oe_n}};
    if (clr) begin strobed = '0; max_cs = 0; end
    if ($countones(~cs_n) > max_cs) max_cs = $countones(~cs_n);
    strobed = strobed | act;
    if (!oe_n && !(&we_n)) viol++;
    if (dq_w_en && ((|drv) || drv_p)) viol++;
    for (int l = 0; l < 4; l++) begin
      if (act[l]) begin
        wcnt[l]++;
        if (!dq_w_en) viol++;
      end else if (act_p[l]) begin
        store[{addr_p, l[1:0]}] = data_p[l*8 +: 8];
        if (wcnt[l] < WR_MIN) viol++;
        if (!we_n[l]) term_cs++; else term_we++;
        wcnt[l] = 0;
      end
      if (drv[l])
        dq_r[l*8 +: 8] = store.exists({addr, l[1:0]}) ? store[{addr, l[1:0]}] : 8'h00;
      else
        dq_r[l*8 +: 8] = 8'h00;
    end
    if (|drv) rcnt++;
    else if (rcnt > 0) begin
      if (rcnt < RD_MIN) viol++;
      rcnt = 0;
    end
    act_p  = act;
    drv_p  = |drv;
    addr_p = addr;
    data_p = dq_w;
  end

endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [1:0]    req_width = '0;
  logic [AW+1:0] req_addr = '0;
  logic [3:0]    req_be = '0;
  logic [31:0]   req_wdata = '0;

  logic          ack_a, ack_b;
  logic [31:0]   rdata_a, rdata_b;
  logic [AW-1:0] addr_a, addr_b;
  logic [31:0]   dqo_a, dqo_b, dqi_a, dqi_b;
  logic          dqoe_a, dqoe_b, oe_a, oe_b;
  logic [3:0]    cs_a, cs_b, we_a, we_b;
  int            viol_a, viol_b, twe_a, twe_b, tcs_a, tcs_b, mcs_a, mcs_b;
  logic [3:0]    stb_a, stb_b;

  int n_chk = 0;
  int n_err = 0;
  int ack_err = 0;

  always #5 clk = ~clk;

  sram_ctrl #(.AW(AW), .WR_END_CS(1'b0)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_width(req_width), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_ack(ack_a), .req_rdata(rdata_a), .mem_addr(addr_a), .mem_dq_o(dqo_a),
    .mem_dq_oe(dqoe_a), .mem_dq_i(dqi_a), .mem_oe_n(oe_a), .mem_cs_n(cs_a), .mem_we_n(we_a)
  );

  sram_ctrl #(.AW(AW), .WR_END_CS(1'b1)) u_dut_cs (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_width(req_width), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_ack(ack_b), .req_rdata(rdata_b), .mem_addr(addr_b), .mem_dq_o(dqo_b),
    .mem_dq_oe(dqoe_b), .mem_dq_i(dqi_b), .mem_oe_n(oe_b), .mem_cs_n(cs_b), .mem_we_n(we_b)
  );

  sram_model #(.AW(AW)) u_mem_a (
    .clk(clk), .clr(clr), .addr(addr_a), .dq_w(dqo_a), .dq_w_en(dqoe_a), .oe_n(oe_a),
    .cs_n(cs_a), .we_n(we_a), .dq_r(dqi_a), .viol(viol_a), .term_we(twe_a),
    .term_cs(tcs_a), .max_cs(mcs_a), .strobed(stb_a)
  );

  sram_model #(.AW(AW)) u_mem_b (
    .clk(clk), .clr(clr), .addr(addr_b), .dq_w(dqo_b), .dq_w_en(dqoe_b), .oe_n(oe_b),
    .cs_n(cs_b), .we_n(we_b), .dq_r(dqi_b), .viol(viol_b), .term_we(twe_b),
    .term_cs(tcs_b), .max_cs(mcs_b), .strobed(stb_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic pulse_clr();
    tick(); clr = 1'b1;
    tick(); clr = 1'b0;
  endtask

  task automatic do_op(input logic wr, input logic [1:0] wid, input logic [AW+1:0] a,
                       input logic [3:0] be, input logic [31:0] wd, output logic [31:0] rd);
    int wait_cnt;
    tick();
    req_write = wr; req_width = wid; req_addr = a; req_be = be; req_wdata = wd;
    req_valid = 1'b1;
    wait_cnt = 0;
    do begin
      tick();
      wait_cnt++;
    end while (!ack_a && wait_cnt < 100);
    if (wait_cnt >= 100) begin
      n_err++;
      $display("FAIL R9: no acknowledge, actual 0 expected 1");
    end
    rd = rdata_a;
    chk("R9 both styles agree on read data", rdata_b, rdata_a);
    req_valid = 1'b0;
    tick();
    if (ack_a || ack_b) ack_err++;
  endtask

  task automatic t_reset();
    chk("R1 reset pins", {16'h0, cs_a, we_a, 1'b0, oe_a, dqoe_a, ack_a, 4'h0},
        {16'h0, 4'hF, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0});
    rst = 1'b0;
    tick();
    chk("R1 pins after reset", {16'h0, cs_b, we_b, 1'b0, oe_b, dqoe_b, ack_b, 4'h0},
        {16'h0, 4'hF, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0});
  endtask

  task automatic t_word32();
    logic [31:0] rd;
    do_op(1'b1, 2'd0, 21'd5, 4'hF, 32'h11223344, rd);
    do_op(1'b0, 2'd0, 21'd5, 4'h0, 32'h0, rd);
    chk("R2 32-bit round trip", rd, 32'h11223344);
    do_op(1'b1, 2'd0, 21'h7FFFF, 4'hF, 32'hDEADBEEF, rd);
    do_op(1'b0, 2'd0, 21'h7FFFF, 4'h0, 32'h0, rd);
    chk("R2 top address round trip", rd, 32'hDEADBEEF);
  endtask

  task automatic t_mask();
    logic [31:0] rd;
    do_op(1'b1, 2'd0, 21'd6, 4'hF, 32'hAABBCCDD, rd);
    pulse_clr();
    do_op(1'b1, 2'd0, 21'd6, 4'b0101, 32'h55667788, rd);
    chk("R3 strobed lanes for mask 0101", {28'h0, stb_a}, 32'h5);
    do_op(1'b0, 2'd0, 21'd6, 4'h0, 32'h0, rd);
    chk("R3 masked lanes kept", rd, 32'hAA66CC88);
  endtask

  task automatic t_half16();
    logic [31:0] rd;
    do_op(1'b1, 2'd1, 21'd21, 4'h3, 32'hFFFFBEEF, rd);
    do_op(1'b1, 2'd1, 21'd20, 4'h3, 32'h0000CAFE, rd);
    do_op(1'b0, 2'd1, 21'd21, 4'h0, 32'h0, rd);
    chk("R4 16-bit read upper pair", rd, 32'h0000BEEF);
    do_op(1'b0, 2'd0, 21'd10, 4'h0, 32'h0, rd);
    chk("R4 16-bit lane placement", rd, 32'hBEEFCAFE);
    do_op(1'b1, 2'd1, 21'd21, 4'h1, 32'h00000012, rd);
    do_op(1'b0, 2'd0, 21'd10, 4'h0, 32'h0, rd);
    chk("R4 16-bit low byte mask", rd, 32'hBE12CAFE);
  endtask

  task automatic t_byte8();
    logic [31:0] rd;
    pulse_clr();
    for (int k = 0; k < 4; k++)
      do_op(1'b1, 2'd2, 21'(48 + k), 4'h1, 32'hFFFFFF00 | 32'(8'hA0 + 8'h11 * k), rd);
    chk("R5 only one chip select in 8-bit mode", 32'(mcs_a), 32'd1);
    do_op(1'b1, 2'd2, 21'd49, 4'h0, 32'h000000EE, rd);
    do_op(1'b0, 2'd0, 21'd12, 4'h0, 32'h0, rd);
    chk("R5 byte lane placement", rd, 32'hD3C2B1A0);
    do_op(1'b0, 2'd2, 21'd50, 4'h0, 32'h0, rd);
    chk("R5 8-bit read zero-extended", rd, 32'h000000C2);
  endtask

  task automatic t_reserved();
    logic [31:0] rd;
    do_op(1'b0, 2'd3, 21'd5, 4'h0, 32'h0, rd);
    chk("R6 width code 3 reads full word", rd, 32'h11223344);
  endtask

  task automatic t_final();
    chk("R7 R8 R11 violations, WE-terminated", 32'(viol_a), 32'd0);
    chk("R7 R8 R11 violations, CS-terminated", 32'(viol_b), 32'd0);
    chk("R9 acknowledge width", 32'(ack_err), 32'd0);
    chk("R10 WE style: no CS-ended writes", 32'(tcs_a), 32'd0);
    chk("R10 WE style: WE-ended writes seen", 32'(twe_a > 0), 32'd1);
    chk("R10 CS style: no WE-ended writes", 32'(twe_b), 32'd0);
    chk("R10 CS style: CS-ended writes seen", 32'(tcs_b > 0), 32'd1);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    t_word32();
    t_mask();
    t_half16();
    t_byte8();
    t_reserved();
    t_final();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule